// File: doc/BRIEF.md
# Pipelined Radix-4 Booth Unsigned Multiplier

This block multiplies two unsigned 24-bit integers and returns the full 48-bit product. It is a Booth multiplier whose iterations have been unrolled into a linear pipeline. A register captures the operands first. After that, twelve stages each retire one radix-4 digit of the multiplier, starting from the least significant pair of bits. Each stage recodes a 3-bit overlapping window into a selection of zero, plus or minus the multiplicand, or plus or minus twice the multiplicand. It adds the weighted partial product to a running sum and hands the operands to the next stage.

A new operand pair may be offered on every clock. A valid flag travels alongside the data, so gaps in the input stream appear unchanged at the output. The running sum is two bits wider than the product, which absorbs the negative partial products. When the multiplier's most significant bit is set, the top digit has a negative weight. The last stage corrects this by adding the multiplicand shifted up by 24 places, so the result is the true unsigned product.

Top module: `booth_pipe_mul`

## Requirements
- R1: When `out_valid` is high, `out_prod` equals the unsigned product `in_a * in_b` of the pair that was accepted, over the full 48 bits.
- R2: A pair presented with `in_valid` high before rising edge n appears with `out_valid` high after rising edge n+12, which is the 13th edge counting the capture edge.
- R3: Pairs presented on consecutive cycles each produce a correct product on consecutive cycles, in the order they were presented.
- R4: While `rst_n` is low, `out_valid` and `out_prod` are 0, and any pairs in flight when reset was asserted never appear at the output.
- R5: Products are correct when bit 23 of the multiplier `in_b` is 1, which is the case where the top Booth digit is negative.
- R6: If either operand is zero, the product is zero.
- R7: A multiplier of 1 returns the multiplicand. A multiplier of 2^k returns the multiplicand shifted left by k bits.
- R8: A cycle with `in_valid` low produces a cycle with `out_valid` low 13 edges later, whatever the operand inputs carried in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The operand pair on `in_a`/`in_b` is to be multiplied |
| in_a | input | 24 | Multiplicand, unsigned |
| in_b | input | 24 | Multiplier, unsigned, consumed two bits per stage |
| out_valid | output | 1 | `out_prod` holds a result |
| out_prod | output | 48 | Unsigned product |

## Verification
The hardest case to reach is the top-digit correction when several negative digits are in flight at once. The running sum then wraps below zero in intermediate stages, and the last stage must bring it back to the true unsigned value. Multipliers with bit 23 set and with alternating bit patterns (all ones, 0xAAAAAA, 0xC00000, 0x800000) are pushed back to back, so that stages hold negative partial sums from different pairs at the same time. A reset in the middle of a stream, followed by idle cycles, shows that flushed pairs never surface.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  // Selected multiple of the multiplicand for one radix-4 digit
  typedef enum logic [2:0] {
    DIG_ZERO = 3'd0,
    DIG_P1   = 3'd1,
    DIG_P2   = 3'd2,
    DIG_M1   = 3'd3,
    DIG_M2   = 3'd4
  } dig_e;

  // Window bits: {upper, lower, borrow-in from the digit below}
  function automatic dig_e recode(input logic [2:0] win);
    dig_e d;
    case (win)
      3'b001, 3'b010: d = DIG_P1;
      3'b011:         d = DIG_P2;
      3'b100:         d = DIG_M2;
      3'b101, 3'b110: d = DIG_M1;
      default:        d = DIG_ZERO;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/booth_mul_inreg.sv
module booth_mul_inreg #(
  parameter int OPW = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           v_i,
  input  logic [OPW-1:0] a_i,
  input  logic [OPW-1:0] b_i,
  output logic           v_o,
  output logic [OPW-1:0] a_o,
  output logic [OPW-1:0] b_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o <= 1'b0;
      a_o <= '0;
      b_o <= '0;
    end else begin
      v_o <= v_i;
      a_o <= a_i;
      b_o <= b_i;
    end
  end

endmodule

// File: rtl/booth_mul_stage.sv
module booth_mul_stage
  import booth_mul_pkg::*;
#(
  parameter int OPW  = 24,
  parameter int IDX  = 0,
  parameter bit LAST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v_i,
  input  logic [OPW-1:0]    mcand_i,
  input  logic [OPW-1:0]    mplr_i,
  input  logic [2*OPW+1:0]  acc_i,
  output logic              v_o,
  output logic [OPW-1:0]    mcand_o,
  output logic [OPW-1:0]    mplr_o,
  output logic [2*OPW+1:0]  acc_o
);

  localparam int PSW = 2*OPW + 2;
  localparam int SH  = 2*IDX;

  logic [2:0]     win;
  dig_e           dig;
  logic [PSW-1:0] mc_ext;
  logic [PSW-1:0] pp_w;
  logic [PSW-1:0] corr_w;
  logic [PSW-1:0] acc_nx;

  // Partial product for one digit, in two's complement over PSW bits
  function automatic logic [PSW-1:0] form_pp(input logic [PSW-1:0] m, input dig_e d);
    logic [PSW-1:0] r;
    case (d)
      DIG_P1:  r = m;
      DIG_P2:  r = m << 1;
      DIG_M1:  r = -m;
      DIG_M2:  r = -(m << 1);
      default: r = '0;
    endcase
    return r;
  endfunction

  generate
    if (IDX == 0) begin : g_first
      assign win = {mplr_i[1:0], 1'b0};
    end else begin : g_mid
      assign win = mplr_i[SH+1:SH-1];
    end
  endgenerate

  assign mc_ext = {{(PSW-OPW){1'b0}}, mcand_i};
  assign dig    = recode(win);
  assign pp_w   = form_pp(mc_ext, dig) << SH;

  // The top digit is read as signed; restore the unsigned weight of the MSB
  generate
    if (LAST) begin : g_corr
      assign corr_w = mplr_i[OPW-1] ? (mc_ext << OPW) : '0;
    end else begin : g_nocorr
      assign corr_w = '0;
    end
  endgenerate

  assign acc_nx = acc_i + pp_w + corr_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o     <= 1'b0;
      mcand_o <= '0;
      mplr_o  <= '0;
      acc_o   <= '0;
    end else begin
      v_o     <= v_i;
      mcand_o <= mcand_i;
      mplr_o  <= mplr_i;
      acc_o   <= acc_nx;
    end
  end

endmodule

// File: rtl/booth_pipe_mul.sv
module booth_pipe_mul #(
  parameter int OPW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OPW-1:0]   in_a,
  input  logic [OPW-1:0]   in_b,
  output logic             out_valid,
  output logic [2*OPW-1:0] out_prod
);

  localparam int NDIG = OPW / 2;
  localparam int PSW  = 2*OPW + 2;

  logic [NDIG:0]  stg_v;
  logic [OPW-1:0] stg_m   [0:NDIG];
  logic [OPW-1:0] stg_y   [0:NDIG];
  logic [PSW-1:0] stg_acc [0:NDIG];

  // Named taps for the checker
  logic [OPW-1:0] last_mcand;
  logic [OPW-1:0] last_mplr;
  logic [1:0]     high_spill;

  booth_mul_inreg #(.OPW(OPW)) u_inreg (
    .clk   (clk),
    .rst_n (rst_n),
    .v_i   (in_valid),
    .a_i   (in_a),
    .b_i   (in_b),
    .v_o   (stg_v[0]),
    .a_o   (stg_m[0]),
    .b_o   (stg_y[0])
  );

  assign stg_acc[0] = '0;

  generate
    for (genvar k = 0; k < NDIG; k++) begin : g_stage
      booth_mul_stage #(
        .OPW  (OPW),
        .IDX  (k),
        .LAST (k == NDIG-1)
      ) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .v_i     (stg_v[k]),
        .mcand_i (stg_m[k]),
        .mplr_i  (stg_y[k]),
        .acc_i   (stg_acc[k]),
        .v_o     (stg_v[k+1]),
        .mcand_o (stg_m[k+1]),
        .mplr_o  (stg_y[k+1]),
        .acc_o   (stg_acc[k+1])
      );
    end
  endgenerate

  assign out_valid  = stg_v[NDIG];
  assign out_prod   = stg_acc[NDIG][2*OPW-1:0];
  assign last_mcand = stg_m[NDIG];
  assign last_mplr  = stg_y[NDIG];
  assign high_spill = stg_acc[NDIG][PSW-1:2*OPW];

endmodule

// File: rtl/booth_pipe_mul_chk.sv
module booth_pipe_mul_chk #(
  parameter int OPW = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [2*OPW-1:0] out_prod,
  input logic [OPW/2:0]   stg_v,
  input logic [OPW-1:0]   last_mcand,
  input logic [OPW-1:0]   last_mplr,
  input logic [1:0]       high_spill
);

  localparam int NDIG = OPW / 2;

  // R2: capture register follows the input flag by one edge
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stg_v[0] == $past(in_valid));

  // R2, R8: each stage hands its flag on one edge later
  generate
    for (genvar k = 0; k < NDIG; k++) begin : g_vstep
      p_valid_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stg_v[k+1] == $past(stg_v[k]));
    end
  endgenerate

  // R1: an unsigned product never spills past 2*OPW bits
  p_no_spill_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> high_spill == 2'b00);

  // R6: zero operand gives zero product
  p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (last_mcand == '0 || last_mplr == '0)) |-> out_prod == '0);

  // R7: unit multiplier returns the multiplicand
  p_unit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && last_mplr == OPW'(1)) |-> out_prod == {{OPW{1'b0}}, last_mcand});

  // R5: with the multiplier MSB set the product is at least mcand * 2^(OPW-1)
  p_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && last_mplr[OPW-1]) |-> out_prod >= ({{OPW{1'b0}}, last_mcand} << (OPW-1)));

  // R4: no result is flagged while reset is held
  p_reset_r4: assert property (@(posedge clk)
    !rst_n |-> !out_valid);

endmodule

bind booth_pipe_mul booth_pipe_mul_chk #(.OPW(OPW)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .out_prod   (out_prod),
  .stg_v      (stg_v),
  .last_mcand (last_mcand),
  .last_mplr  (last_mplr),
  .high_spill (high_spill)
);

// File: tb/test_booth_pipe_mul.sv
module test_booth_pipe_mul;

  localparam int OPW  = 24;
  localparam int LAT  = 13;
  localparam int NVEC = 12;
  localparam int HD   = 256;

  // {multiplicand, multiplier}
  localparam logic [47:0] VEC [NVEC] = '{
    {24'h000003, 24'h000005},   // R1 small values
    {24'hFFFFFF, 24'hFFFFFF},   // R5 all ones
    {24'h123456, 24'h800000},   // R5 only MSB of multiplier
    {24'hABCDEF, 24'h000001},   // R7 unit
    {24'h000000, 24'hFFFFFF},   // R6 zero multiplicand
    {24'hFFFFFF, 24'h000000},   // R6 zero multiplier
    {24'h7FFFFF, 24'hAAAAAA},   // R5 many negative digits
    {24'h555555, 24'h555555},   // R1 alternating bits
    {24'h000001, 24'hC00000},   // R5 top pair set
    {24'hDEADBE, 24'hEF1234},   // R3 arbitrary
    {24'h800000, 24'h800000},   // R5 both MSBs
    {24'h3C3C3C, 24'h000400}    // R7 power of two
  };
  localparam int VTAG [NVEC] = '{1, 5, 5, 7, 6, 6, 5, 1, 5, 3, 5, 7};

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid = 1'b0;
  logic [OPW-1:0]   in_a = '0;
  logic [OPW-1:0]   in_b = '0;
  logic             out_valid;
  logic [2*OPW-1:0] out_prod;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit chk_on = 1'b0;

  logic           vh [HD];
  logic [OPW-1:0] ah [HD];
  logic [OPW-1:0] bh [HD];
  int             th [HD];

  always #10 clk = ~clk;

  booth_pipe_mul #(.OPW(OPW)) i_booth_pipe_mul (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_prod  (out_prod)
  );

  // Shift-and-add reference over the multiplier bits
  function automatic logic [47:0] ref_mul(input logic [23:0] a, input logic [23:0] b);
    logic [47:0] s = '0;
    for (int k = 0; k < 24; k++)
      if (b[k]) s = s + ({24'h0, a} << k);
    return s;
  endfunction

  task automatic clear_hist();
    for (int i = 0; i < HD; i++) begin
      vh[i] = 1'b0; ah[i] = '0; bh[i] = '0; th[i] = 0;
    end
  endtask

  // One cycle: check outputs at the falling edge, then drive new inputs
  task automatic step(input logic v, input logic [23:0] a, input logic [23:0] b, input int tag);
    int j;
    logic [47:0] exp_p;
    @(negedge clk);
    cyc++;
    if (chk_on && cyc >= LAT) begin
      j = (cyc - LAT) % HD;
      checks++;
      if (out_valid !== vh[j]) begin
        fails++;
        $display("FAIL R2/R8 out_valid at cycle %0d: got %b expected %b", cyc, out_valid, vh[j]);
      end
      if (vh[j]) begin
        exp_p = ref_mul(ah[j], bh[j]);
        checks++;
        if (out_prod !== exp_p) begin
          fails++;
          $display("FAIL R%0d product %h*%h: got %h expected %h", th[j], ah[j], bh[j], out_prod, exp_p);
        end
      end
    end
    vh[cyc % HD] = v;
    ah[cyc % HD] = a;
    bh[cyc % HD] = b;
    th[cyc % HD] = tag;
    in_valid = v;
    in_a     = a;
    in_b     = b;
  endtask

  task automatic check_reset_outputs(input string when);
    checks++;
    if (out_valid !== 1'b0 || out_prod !== '0) begin
      fails++;
      $display("FAIL R4 %s: got valid=%b prod=%h expected valid=0 prod=0", when, out_valid, out_prod);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    clear_hist();
    for (int i = 0; i < 3; i++) step(1'b0, '0, '0, 4);
    check_reset_outputs("initial reset");   // R4
    rst_n = 1'b1;
    chk_on = 1'b1;

    // R1 R3 R5 R6 R7: table streamed back to back
    for (int i = 0; i < NVEC; i++)
      step(1'b1, VEC[i][47:24], VEC[i][23:0], VTAG[i]);
    // R7: shifts by several powers of two
    for (int k = 0; k < 24; k += 5)
      step(1'b1, 24'h9ABCDE, 24'h000001 << k, 7);
    for (int i = 0; i < LAT + 2; i++) step(1'b0, '0, '0, 8);

    // R8: bubbles carrying junk operands, mixed with R5 pairs
    for (int i = 0; i < 20; i++) begin
      if (i % 3 == 1) step(1'b0, 24'hFFFFFF, 24'hFFFFFF, 8);
      else            step(1'b1, 24'hF0F0F0 ^ OPW'(i * 7919), 24'h800001 | OPW'(i << 9), 5);
    end
    for (int i = 0; i < LAT + 2; i++) step(1'b0, 24'hABCDEF, 24'h123456, 8);

    // R4: reset in mid-stream flushes the pairs in flight
    for (int i = 0; i < 6; i++) step(1'b1, 24'h111111 * OPW'(i + 1), 24'hFEDCBA, 3);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_outputs("mid-stream reset");
    clear_hist();
    for (int i = 0; i < 3; i++) step(1'b0, '0, '0, 4);
    check_reset_outputs("held reset");
    rst_n = 1'b1;
    for (int i = 0; i < LAT + 4; i++) step(1'b0, 24'h5A5A5A, 24'hA5A5A5, 4);

    // R2 R3: single lone pair then a final burst
    step(1'b1, 24'h000ABC, 24'hFFF000, 2);
    for (int i = 0; i < 8; i++) step(1'b0, '0, '0, 2);
    for (int i = 0; i < 8; i++) step(1'b1, 24'hFFFFFF - OPW'(i), 24'hAAAAAA + OPW'(i), 3);
    for (int i = 0; i < LAT + 2; i++) step(1'b0, '0, '0, 8);

    summary();
    $finish;
  end

endmodule